// File: doc/BRIEF.md
# LPI Table Base Register Unit

This block is the per-processor register unit that tells an interrupt controller where its locality-specific interrupt tables live in memory. It holds two 64-bit base registers, one for the configuration (property) table and one for the pending table. It also holds a control word with an enable bit and a read-only identification word. The identification word reports the processor's affinity, its number, whether it is the last processor online and whether LPI support is present.

A 64-bit wide register bus reaches the unit. Addresses count 32-bit words: bit 0 picks the half of a 64-bit register and bits 2:1 pick the register. A write is either one full 64-bit access or a 32-bit access that replaces one half. Each value headed for a base register first passes through a combinational sanitiser. The sanitiser rewrites illegal memory-attribute codes into legal ones and zeroes reserved bits, so software always reads back what the hardware will use. Once LPIs are enabled, both base registers are frozen. The enable's 0-to-1 edge produces a one-cycle pulse that starts the table walker downstream.

Top module: `lpi_table_regs`

## Requirements
- R1: After reset both base registers read zero, the enable is 0 and the enable pulse is 0.
- R2: Register select `addr[2:1]` is: 0 control, 1 identification, 2 property base, 3 pending base. Higher address bits must be zero for a hit. `rdata` returns the full 64-bit selected register in the same cycle; a miss reads zero. The control word returns the enable in bit 0 and zero elsewhere.
- R3: A write with `wr_wide`=1 replaces all 64 bits of the target. With `wr_wide`=0 it takes `wdata[31:0]` into bits 31:0 when `addr[0]`=0 and into bits 63:32 when `addr[0]`=1, leaving the other half unchanged.
- R4: Shareability (bits 11:10): code 2 is stored as 1; codes 0, 1 and 3 are kept.
- R5: Inner cacheability (bits 9:7): codes 0 and 1 are stored as 3; codes 2..7 are kept.
- R6: Outer cacheability (bits 58:56): codes 0 and 1 are kept; every other code is stored as 1.
- R7: The property base stores bits 63:59, 55:48 and 6:5 as zero.
- R8: The pending base stores bits 63, 61:59, 55:48, 15:12 and 6:0 as zero; bit 62 is kept.
- R9: While the enable is 1, writes to either base register leave it unchanged.
- R10: A control write that reaches bit 0 (`wr_wide`=1, or `addr[0]`=0) loads the enable from `wdata[0]` only when `lpis_present` is 1; otherwise the enable is unchanged. Writes to the control upper half and to the identification word change nothing.
- R11: `lpi_enable_pulse` is 1 for exactly the one cycle in which the enable first reads 1 after being 0.
- R12: The identification word holds `cpu_aff` in bits 55:32, `cpu_num` in bits 23:8, bit 4 = (`cpu_num` == `last_num`), bit 0 = `lpis_present`, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| addr | input | ADDR_W (3) | Word address: bit 0 half, bits 2:1 register |
| wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| lpis_present | input | 1 | LPI support strap |
| cpu_aff | input | AFF_W (24) | Processor affinity |
| cpu_num | input | CPU_W (16) | This processor's number |
| last_num | input | CPU_W (16) | Highest online processor number |
| rdata | output | 64 | Read data for `addr` |
| lpi_enabled | output | 1 | Current enable state |
| lpi_enable_pulse | output | 1 | One-cycle pulse on enable rising |
| prop_base | output | 64 | Stored property table base |
| pend_base | output | 64 | Stored pending table base |

## Verification
A wrong stored value in a base register appears on `prop_base` or `pend_base` one clock after the write that caused it. It stays visible there until the next accepted write, so a per-cycle comparison against a behavioural model catches it at once. A bad enable state shows on `lpi_enabled` the same cycle. It also shows one cycle later as a write that was wrongly accepted or wrongly dropped by a frozen base register. Random full and half writes with arbitrary attribute codes reach every sanitiser branch. The strap is toggled so that refused enables are also covered.

// File: rtl/lpi_regs_pkg.sv
package lpi_regs_pkg;
   localparam int REG_W = 64;

   // attribute field low bit positions
   localparam int SH_LO = 10;
   localparam int IC_LO = 7;
   localparam int OC_LO = 56;

   localparam logic [1:0] SH_OUTER = 2'd2;
   localparam logic [1:0] SH_INNER = 2'd1;

   localparam logic [2:0] CA_DEVICE = 3'd0;
   localparam logic [2:0] CA_NONC   = 3'd1;
   localparam logic [2:0] CA_RAWB   = 3'd3;

   // bits forced to zero on store
   localparam logic [REG_W-1:0] PROP_RSVD = 64'hF8FF_0000_0000_0060;
   localparam logic [REG_W-1:0] PEND_RSVD = 64'hB8FF_0000_0000_F07F;

   // identification word layout
   localparam int ID_LPI_BIT  = 0;
   localparam int ID_LAST_BIT = 4;
   localparam int ID_NUM_LO   = 8;
   localparam int ID_AFF_LO   = 32;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_ID   = 2'd1,
      SEL_PROP = 2'd2,
      SEL_PEND = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/lpi_attr_sanitizer.sv
module lpi_attr_sanitizer
   import lpi_regs_pkg::*;
#(
   parameter bit PEND_VARIANT = 1'b0
) (
   input  logic [REG_W-1:0] raw,
   output logic [REG_W-1:0] clean
);
   logic [REG_W-1:0] rsvd;

   generate
      if (PEND_VARIANT) begin : g_pend
         assign rsvd = PEND_RSVD;
      end else begin : g_prop
         assign rsvd = PROP_RSVD;
      end
   endgenerate

   logic [1:0] sh_in, sh_out;
   logic [2:0] ic_in, ic_out;
   logic [2:0] oc_in, oc_out;

   assign sh_in = raw[SH_LO +: 2];
   assign ic_in = raw[IC_LO +: 3];
   assign oc_in = raw[OC_LO +: 3];

   always_comb begin
      sh_out = (sh_in == SH_OUTER) ? SH_INNER : sh_in;
      ic_out = ((ic_in == CA_DEVICE) || (ic_in == CA_NONC)) ? CA_RAWB : ic_in;
      oc_out = ((oc_in == CA_DEVICE) || (oc_in == CA_NONC)) ? oc_in : CA_NONC;
   end

   always_comb begin
      clean = raw;
      clean[SH_LO +: 2] = sh_out;
      clean[IC_LO +: 3] = ic_out;
      clean[OC_LO +: 3] = oc_out;
      clean = clean & ~rsvd;
   end
endmodule

// File: rtl/lpi_base_reg.sv
module lpi_base_reg
   import lpi_regs_pkg::*;
#(
   parameter bit PEND_VARIANT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_wide,
   input  logic             hi_sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             freeze,
   output logic [REG_W-1:0] q
);
   localparam int HALF = REG_W / 2;

   logic [REG_W-1:0] merged, cleaned;
   logic             take;

   always_comb begin
      if (wr_wide)
         merged = wdata;
      else if (hi_sel)
         merged = {wdata[HALF-1:0], q[HALF-1:0]};
      else
         merged = {q[REG_W-1:HALF], wdata[HALF-1:0]};
   end

   lpi_attr_sanitizer #(.PEND_VARIANT(PEND_VARIANT)) i_san (
      .raw   (merged),
      .clean (cleaned)
   );

   assign take = wr_en && !freeze;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (take) q <= cleaned;
   end

   // R9
   frozen_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(q));

   // R5
   inner_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (q[IC_LO +: 3] >= 3'd2));

   // R4
   share_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q[SH_LO +: 2] != SH_OUTER);

   // R6
   outer_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q[OC_LO +: 3] <= CA_NONC);

   generate
      if (PEND_VARIANT) begin : g_chk_pend
         // R8
         pend_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q & PEND_RSVD) == '0);
      end else begin : g_chk_prop
         // R7
         prop_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q & PROP_RSVD) == '0);
      end
   endgenerate
endmodule

// File: rtl/lpi_id_word.sv
module lpi_id_word
   import lpi_regs_pkg::*;
#(
   parameter int AFF_W = 24,
   parameter int CPU_W = 16
) (
   input  logic [AFF_W-1:0] cpu_aff,
   input  logic [CPU_W-1:0] cpu_num,
   input  logic [CPU_W-1:0] last_num,
   input  logic             lpis_present,
   output logic [REG_W-1:0] id_word
);
   always_comb begin
      id_word = '0;
      id_word[ID_AFF_LO +: AFF_W] = cpu_aff;
      id_word[ID_NUM_LO +: CPU_W] = cpu_num;
      id_word[ID_LAST_BIT]        = (cpu_num == last_num);
      id_word[ID_LPI_BIT]         = lpis_present;
   end
endmodule

// File: rtl/lpi_table_regs.sv
module lpi_table_regs
   import lpi_regs_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int AFF_W  = 24,
   parameter int CPU_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_wide,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              lpis_present,
   input  logic [AFF_W-1:0]  cpu_aff,
   input  logic [CPU_W-1:0]  cpu_num,
   input  logic [CPU_W-1:0]  last_num,
   output logic [REG_W-1:0]  rdata,
   output logic              lpi_enabled,
   output logic              lpi_enable_pulse,
   output logic [REG_W-1:0]  prop_base,
   output logic [REG_W-1:0]  pend_base
);
   localparam int SEL_LO = 1;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (AFF_W < 1 || AFF_W > 24) begin : g_bad_aff
         $error("AFF_W must be 1..24");
      end
      if (CPU_W < 1 || CPU_W > 16) begin : g_bad_cpu
         $error("CPU_W must be 1..16");
      end
   endgenerate

   logic     hit;
   reg_sel_e sel;
   logic     hi_sel;

   generate
      if (ADDR_W > 3) begin : g_wide_addr
         assign hit = (addr[ADDR_W-1:3] == '0);
      end else begin : g_exact_addr
         assign hit = 1'b1;
      end
   endgenerate

   assign sel    = reg_sel_e'(addr[SEL_LO +: 2]);
   assign hi_sel = addr[0];

   logic wr_prop, wr_pend, wr_ctl;
   assign wr_prop = wr_en && hit && (sel == SEL_PROP);
   assign wr_pend = wr_en && hit && (sel == SEL_PEND);
   assign wr_ctl  = wr_en && hit && (sel == SEL_CTL) && (wr_wide || !hi_sel);

   lpi_base_reg #(.PEND_VARIANT(1'b0)) i_prop (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_prop),
      .wr_wide (wr_wide),
      .hi_sel  (hi_sel),
      .wdata   (wdata),
      .freeze  (lpi_enabled),
      .q       (prop_base)
   );

   lpi_base_reg #(.PEND_VARIANT(1'b1)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_pend),
      .wr_wide (wr_wide),
      .hi_sel  (hi_sel),
      .wdata   (wdata),
      .freeze  (lpi_enabled),
      .q       (pend_base)
   );

   logic [REG_W-1:0] id_word;

   lpi_id_word #(.AFF_W(AFF_W), .CPU_W(CPU_W)) i_id (
      .cpu_aff      (cpu_aff),
      .cpu_num      (cpu_num),
      .last_num     (last_num),
      .lpis_present (lpis_present),
      .id_word      (id_word)
   );

   logic ctl_load;
   assign ctl_load = wr_ctl && lpis_present;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpi_enabled      <= 1'b0;
         lpi_enable_pulse <= 1'b0;
      end else begin
         if (ctl_load) lpi_enabled <= wdata[0];
         lpi_enable_pulse <= ctl_load && wdata[0] && !lpi_enabled;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_CTL:  rdata[0] = lpi_enabled;
            SEL_ID:   rdata = id_word;
            SEL_PROP: rdata = prop_base;
            SEL_PEND: rdata = pend_base;
         endcase
      end
   end

   // R11
   pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpi_enable_pulse |-> (lpi_enabled && !$past(lpi_enabled)));

   // R11
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpi_enable_pulse |=> !lpi_enable_pulse);

   // R10
   strap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lpi_enabled) |-> $past(lpis_present));
endmodule

// File: tb/test_lpi_table_regs.sv
module test_lpi_table_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_wide = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [63:0] wdata = 64'd0;
   logic        lpis_present = 1'b1;
   logic [23:0] cpu_aff = 24'h0;
   logic [15:0] cpu_num = 16'h0;
   logic [15:0] last_num = 16'h0;
   logic [63:0] rdata, prop_base, pend_base;
   logic        lpi_enabled, lpi_enable_pulse;

   integer total = 0;
   integer bad = 0;
   bit     done = 1'b0;

   always #5 clk = ~clk;

   lpi_table_regs i_lpi_table_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .addr(addr),
      .wdata(wdata), .lpis_present(lpis_present), .cpu_aff(cpu_aff),
      .cpu_num(cpu_num), .last_num(last_num), .rdata(rdata),
      .lpi_enabled(lpi_enabled), .lpi_enable_pulse(lpi_enable_pulse),
      .prop_base(prop_base), .pend_base(pend_base)
   );

   // ---------------- reference model ----------------
   logic [63:0] m_prop, m_pend;
   logic        m_en, m_pulse;

   function automatic logic [63:0] ref_clean(input logic [63:0] v, input bit pend);
      logic [63:0] r;
      logic [63:0] kill;
      r = v;
      if (r[11:10] == 2'b10) r[11:10] = 2'b01;
      if (r[9:7] < 3'd2) r[9:7] = 3'd3;
      if (r[58:56] > 3'd1) r[58:56] = 3'd1;
      kill = '0;
      if (pend) begin
         kill[63] = 1'b1;
         for (int b = 59; b <= 61; b++) kill[b] = 1'b1;
         for (int b = 12; b <= 15; b++) kill[b] = 1'b1;
         for (int b = 0; b <= 6; b++) kill[b] = 1'b1;
      end else begin
         for (int b = 59; b <= 63; b++) kill[b] = 1'b1;
         for (int b = 5; b <= 6; b++) kill[b] = 1'b1;
      end
      for (int b = 48; b <= 55; b++) kill[b] = 1'b1;
      return r & ~kill;
   endfunction

   function automatic logic [63:0] ref_merge(input logic [63:0] old, input logic [63:0] d,
                                             input logic wide, input logic hi);
      if (wide) return d;
      if (hi) return {d[31:0], old[31:0]};
      return {old[63:32], d[31:0]};
   endfunction

   function automatic logic [63:0] ref_read();
      logic [63:0] r;
      r = 64'd0;
      case (addr[2:1])
         2'd0: r = {63'd0, m_en};
         2'd1: begin
            r[55:32] = cpu_aff;
            r[23:8]  = cpu_num;
            r[4]     = (cpu_num == last_num);
            r[0]     = lpis_present;
         end
         2'd2: r = m_prop;
         default: r = m_pend;
      endcase
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prop <= 64'd0; m_pend <= 64'd0; m_en <= 1'b0; m_pulse <= 1'b0;
      end else begin
         m_pulse <= 1'b0;
         if (wr_en) begin
            if (addr[2:1] == 2'd2 && !m_en)
               m_prop <= ref_clean(ref_merge(m_prop, wdata, wr_wide, addr[0]), 1'b0);
            if (addr[2:1] == 2'd3 && !m_en)
               m_pend <= ref_clean(ref_merge(m_pend, wdata, wr_wide, addr[0]), 1'b1);
            if (addr[2:1] == 2'd0 && (wr_wide || !addr[0]) && lpis_present) begin
               m_en <= wdata[0];
               m_pulse <= wdata[0] && !m_en;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(prop_base == m_prop, "R3/R4/R5/R6/R7/R9 prop", prop_base, m_prop);
         check(pend_base == m_pend, "R3/R4/R5/R6/R8/R9 pend", pend_base, m_pend);
         check(lpi_enabled == m_en, "R10 enable", {63'd0, lpi_enabled}, {63'd0, m_en});
         check(lpi_enable_pulse == m_pulse, "R11 pulse",
               {63'd0, lpi_enable_pulse}, {63'd0, m_pulse});
         check(rdata == ref_read(), "R2/R12 rdata", rdata, ref_read());
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic en, input logic wide, input logic [2:0] a,
                        input logic [63:0] d);
      @(posedge clk); #2;
      wr_en = en; wr_wide = wide; addr = a; wdata = d;
   endtask

   task automatic settle();
      drive(1'b0, 1'b0, addr, 64'd0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(prop_base == 64'd0 && pend_base == 64'd0, "R1 bases zero", prop_base, 64'd0);
      check(!lpi_enabled && !lpi_enable_pulse, "R1 enable off",
            {62'd0, lpi_enabled, lpi_enable_pulse}, 64'd0);

      // R7 R6: all ones into property base
      drive(1'b1, 1'b1, 3'd4, '1); settle();
      check(prop_base == 64'h0100_FFFF_FFFF_FF9F, "R7 prop all-ones", prop_base,
            64'h0100_FFFF_FFFF_FF9F);
      // R8 R6: all ones into pending base
      drive(1'b1, 1'b1, 3'd6, '1); settle();
      check(pend_base == 64'h4100_FFFF_FFFF_0F80, "R8 pend all-ones", pend_base,
            64'h4100_FFFF_FFFF_0F80);
      // R4 R5 R6 rewrite codes
      drive(1'b1, 1'b1, 3'd4, 64'h0200_0000_0000_0800); settle();
      check(prop_base == 64'h0100_0000_0000_0580, "R4 R5 R6 code rewrite", prop_base,
            64'h0100_0000_0000_0580);
      // R3 upper half
      drive(1'b1, 1'b0, 3'd5, 64'hFFFF_FFFF_0000_1234); settle();
      check(prop_base == 64'h0000_1234_0000_0580, "R3 upper half", prop_base,
            64'h0000_1234_0000_0580);
      // R3 lower half
      drive(1'b1, 1'b0, 3'd4, 64'h0000_0000_ABCD_0400); settle();
      check(prop_base == 64'h0000_1234_ABCD_0580, "R3 lower half", prop_base,
            64'h0000_1234_ABCD_0580);
      // R2 read of property
      drive(1'b0, 1'b0, 3'd4, 64'd0); @(negedge clk);
      check(rdata == 64'h0000_1234_ABCD_0580, "R2 read prop", rdata, 64'h0000_1234_ABCD_0580);

      // R12 identification word
      cpu_aff = 24'hA1B2C3; cpu_num = 16'h0007; last_num = 16'h0007;
      drive(1'b0, 1'b0, 3'd2, 64'd0); @(negedge clk);
      check(rdata == 64'h00A1_B2C3_0000_0711, "R12 last cpu", rdata, 64'h00A1_B2C3_0000_0711);
      last_num = 16'h0009;
      #1;
      check(rdata == 64'h00A1_B2C3_0000_0701, "R12 not last", rdata, 64'h00A1_B2C3_0000_0701);

      // R10 strap off: enable refused
      lpis_present = 1'b0;
      drive(1'b1, 1'b1, 3'd0, 64'd1); settle();
      check(!lpi_enabled, "R10 strap blocks", {63'd0, lpi_enabled}, 64'd0);
      // R10 upper-half control write ignored
      lpis_present = 1'b1;
      drive(1'b1, 1'b0, 3'd1, 64'd1); settle();
      check(!lpi_enabled, "R10 upper half ignored", {63'd0, lpi_enabled}, 64'd0);
      // R11 enable and pulse
      drive(1'b1, 1'b0, 3'd0, 64'd1);
      @(negedge clk);
      check(!lpi_enable_pulse, "R11 no early pulse", {63'd0, lpi_enable_pulse}, 64'd0);
      drive(1'b0, 1'b0, 3'd0, 64'd0); @(negedge clk);
      check(lpi_enabled && lpi_enable_pulse, "R11 pulse high",
            {62'd0, lpi_enabled, lpi_enable_pulse}, 64'd3);
      @(negedge clk);
      check(lpi_enabled && !lpi_enable_pulse, "R11 pulse one cycle",
            {62'd0, lpi_enabled, lpi_enable_pulse}, 64'd2);
      check(rdata == 64'd1, "R2 control read", rdata, 64'd1);
      // R9 base frozen
      drive(1'b1, 1'b1, 3'd6, 64'h0000_0000_1234_5000); settle();
      check(pend_base == 64'h4100_FFFF_FFFF_0F80, "R9 pend frozen", pend_base,
            64'h4100_FFFF_FFFF_0F80);
      // R11 re-enable while on: no pulse
      drive(1'b1, 1'b1, 3'd0, 64'd1); settle();
      check(!lpi_enable_pulse, "R11 no pulse when already on",
            {63'd0, lpi_enable_pulse}, 64'd0);
      // R10 disable then base writable again
      drive(1'b1, 1'b1, 3'd0, 64'd0); settle();
      check(!lpi_enabled, "R10 disable", {63'd0, lpi_enabled}, 64'd0);

      // random phase: the per-cycle model comparison does the checking
      for (int i = 0; i < 4000; i++) begin
         int k;
         logic [2:0] a;
         k = $urandom_range(0, 99);
         if (i % 500 == 499) lpis_present = ~lpis_present;
         if (k < 15) a = {2'd0, 1'($urandom_range(0, 1))};
         else if (k < 20) a = 3'($urandom_range(2, 3));
         else a = {1'b1, 2'($urandom_range(0, 3))};
         cpu_num = 16'($urandom_range(0, 3));
         last_num = 16'($urandom_range(0, 3));
         cpu_aff = 24'($urandom);
         drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), a,
               {32'($urandom), 32'($urandom)});
      end
      drive(1'b0, 1'b0, 3'd0, 64'd0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule